// File: doc/BRIEF.md
# Page Write Program-Cycle Controller

This block sits behind the serial bus engine of a two-wire byte-addressed nonvolatile memory. The engine reports decoded events to it: a loaded start address, each received data byte together with the state of the write-protect input, the end of each acknowledge bit, every later bit clock, START and STOP. The block gathers the accepted data bytes of a single- or multi-byte write into a one-row latch. A per-byte mask records which columns were actually received. It then decides whether the terminating STOP opens a program cycle.

A program cycle runs for a parameterised number of system clocks. During it the block raises `busy`, and every event input is ignored. The bus engine uses `busy` to leave device-select bytes unacknowledged, so a master can poll for completion. When the count expires, the masked bytes are copied into a behavioural byte array in one step, and the block accepts traffic again. A read port exposes the array, and the address counter is visible as an output.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset `busy` is 0, `addr_cnt` is 0 and every array byte reads FFh.
- R2: A STOP seen while the acknowledge slot is armed, with at least one byte latched, raises `busy` on the next clock edge. `busy` then stays high for exactly WRITE_CYCLES clocks. The latched byte is readable on `rd_data` once `busy` is low.
- R3: Several data bytes in one write land at consecutive columns of the addressed row and are all committed in the same program cycle.
- R4: Each received data byte, whether accepted or refused, advances only the low six bits of `addr_cnt`, modulo 64. The bits above them stay unchanged, so a byte past column 63 goes to column 0 of the same row and replaces the byte latched there earlier.
- R5: Columns of the row that received no byte keep their previous array contents.
- R6: The slot is armed by `ack_evt` and disarmed by `bit_evt`, `start_evt` or `stop_evt`. A STOP while it is disarmed starts no cycle and discards the latched bytes.
- R7: A data byte presented with `wp_in` = 1 is not latched and leaves its array location unchanged. A write in which every byte was refused starts no cycle.
- R8: `addr_we` loads `addr_in` into `addr_cnt` on the next edge. A STOP after the address with no data bytes leaves `addr_cnt` at that address and starts no cycle.
- R9: While `busy` is high, `addr_we`, `byte_we`, `stop_evt` and the other events have no effect on `addr_cnt`, the latch or the array.
- R10: In the clock after `busy` falls, a new address load and write are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | START decoded (one-clock pulse) |
| addr_we | input | 1 | Two address bytes received; load `addr_in` |
| addr_in | input | ADDR_W | Start address of the write |
| byte_we | input | 1 | Data byte received |
| byte_in | input | 8 | Data byte value |
| wp_in | input | 1 | Write-protect state for the byte on `byte_we` |
| ack_evt | input | 1 | An acknowledge bit just ended |
| bit_evt | input | 1 | A further bit clock after the acknowledge |
| stop_evt | input | 1 | STOP decoded |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| busy | output | 1 | Program cycle running |
| addr_cnt | output | ADDR_W | Current address counter |

## Verification
A wrong address counter appears on `addr_cnt` on the clock after the offending byte, and it also shows as data at the wrong column once the cycle completes. A wrong slot or mask state only becomes visible through `busy`, either raised or not raised on the edge after STOP, or through `rd_data` after the full WRITE_CYCLES window. For that reason the bench reads back whole rows, including the neighbours of each written column. A timer fault shows as a `busy` pulse of the wrong length.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    localparam int COL_W     = 6;
    localparam int ROW_BYTES = 1 << COL_W;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter int WRITE_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = tmr_q.busy && (tmr_q.cnt == CNT_W'(1));
        if (tmr_q.busy) begin
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
            if (done) tmr_d.busy = 1'b0;
        end else if (load) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(WRITE_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
endmodule

// File: rtl/pgwr_row_latch.sv
module pgwr_row_latch
    import pgwr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr,
    input  logic [COL_W-1:0]     col,
    input  byte_t                din,
    output byte_t                data [ROW_BYTES],
    output logic [ROW_BYTES-1:0] mask
);
    byte_t                data_d [ROW_BYTES];
    byte_t                data_q [ROW_BYTES];
    logic [ROW_BYTES-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        for (int c = 0; c < ROW_BYTES; c++) data_d[c] = data_q[c];
        if (clr) begin
            mask_d = '0;
        end else if (wr) begin
            data_d[col] = din;
            mask_d[col] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            for (int c = 0; c < ROW_BYTES; c++) data_q[c] <= '0;
        end else begin
            mask_q <= mask_d;
            for (int c = 0; c < ROW_BYTES; c++) data_q[c] <= data_d[c];
        end
    end

    assign mask = mask_q;
    always_comb for (int c = 0; c < ROW_BYTES; c++) data[c] = data_q[c];
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array
    import pgwr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [ADDR_W-COL_W-1:0] row,
    input  byte_t                   row_data [ROW_BYTES],
    input  logic [ROW_BYTES-1:0]    row_mask,
    input  logic [ADDR_W-1:0]       rd_addr,
    output byte_t                   rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (commit) begin
            for (int c = 0; c < ROW_BYTES; c++)
                if (row_mask[c]) mem_q[{row, COL_W'(c)}] <= row_data[c];
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int WRITE_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_we,
    input  logic [7:0]        byte_in,
    input  logic              wp_in,
    input  logic              ack_evt,
    input  logic              bit_evt,
    input  logic              stop_evt,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic [ADDR_W-1:0] addr_cnt
);
    localparam int ROW_W = ADDR_W - COL_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              armed;
    } ctl_t;

    ctl_t                 st_d, st_q;
    logic                 go, trigger, done, lat_clr, lat_wr;
    byte_t                lat_data [ROW_BYTES];
    logic [ROW_BYTES-1:0] lat_mask;

    always_comb begin
        st_d    = st_q;
        go      = !busy;
        trigger = go && stop_evt && st_q.armed && (|lat_mask);
        lat_wr  = go && byte_we && !addr_we && !wp_in;
        lat_clr = done || (go && (addr_we || (stop_evt && !trigger)));

        if (go) begin
            if (addr_we) begin
                st_d.addr = addr_in;
            end else if (byte_we) begin
                st_d.addr = {st_q.addr[ADDR_W-1:COL_W],
                             st_q.addr[COL_W-1:0] + COL_W'(1)};
            end
            if (ack_evt)                             st_d.armed = 1'b1;
            else if (bit_evt || start_evt || stop_evt) st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pgwr_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (trigger),
        .busy (busy),
        .done (done)
    );

    pgwr_row_latch u_lat (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (lat_clr),
        .wr   (lat_wr),
        .col  (st_q.addr[COL_W-1:0]),
        .din  (byte_in),
        .data (lat_data),
        .mask (lat_mask)
    );

    pgwr_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (done),
        .row     (st_q.addr[ADDR_W-1:COL_W]),
        .row_data(lat_data),
        .row_mask(lat_mask),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign addr_cnt = st_q.addr;

    logic [ROW_W-1:0] unused_row;
    assign unused_row = '0;
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk
    import pgwr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_we,
    input logic [ADDR_W-1:0] addr_in,
    input logic              byte_we,
    input logic              stop_evt,
    input logic              armed,
    input logic              busy,
    input logic [ADDR_W-1:0] addr_cnt
);
    AST_BUSY_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_cnt)); // R9

    AST_ROW_BITS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && !addr_we && !busy) |=>
            addr_cnt[ADDR_W-1:COL_W] == $past(addr_cnt[ADDR_W-1:COL_W])); // R4

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && !addr_we && !busy) |=>
            addr_cnt[COL_W-1:0] == COL_W'($past(addr_cnt[COL_W-1:0]) + COL_W'(1))); // R4

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_we && !busy) |=> addr_cnt == $past(addr_in)); // R8

    AST_BUSY_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt)); // R2

    AST_NO_CYCLE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !armed && !busy) |=> !busy); // R6
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_we (addr_we),
    .addr_in (addr_in),
    .byte_we (byte_we),
    .stop_evt(stop_evt),
    .armed   (st_q.armed),
    .busy    (busy),
    .addr_cnt(addr_cnt)
);

// File: tb/sim_pgwr_ctrl.sv
module sim_pgwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;
    localparam int WCYC       = 20;
    localparam int DEPTH      = 1 << AW;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          start_evt = 0, addr_we = 0, byte_we = 0, wp_in = 0;
    logic          ack_evt = 0, bit_evt = 0, stop_evt = 0;
    logic [AW-1:0] addr_in = '0, rd_addr = '0, addr_cnt;
    logic [7:0]    byte_in = '0, rd_data;
    logic          busy;

    int checks = 0, fails = 0;
    bit finished = 0;

    typedef struct { int addr; int data; string tag; } exp_t;
    exp_t exp_q[$];
    int   model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwr_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WCYC)) u0 (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .addr_we(addr_we),
        .addr_in(addr_in), .byte_we(byte_we), .byte_in(byte_in), .wp_in(wp_in),
        .ack_evt(ack_evt), .bit_evt(bit_evt), .stop_evt(stop_evt),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .addr_cnt(addr_cnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        start_evt = 0; addr_we = 0; byte_we = 0; wp_in = 0;
        ack_evt = 0; bit_evt = 0; stop_evt = 0;
    endtask

    task automatic send_addr(input int a);
        @(negedge clk); start_evt = 1;
        idle();         addr_we = 1; addr_in = AW'(a);
        idle();         ack_evt = 1;
        idle();
    endtask

    task automatic send_byte(input int d, input bit wp, input bit ack);
        @(negedge clk); byte_we = 1; byte_in = 8'(d); wp_in = wp;
        idle();
        if (ack) begin ack_evt = 1; idle(); end
    endtask

    task automatic send_stop();
        @(negedge clk); stop_evt = 1;
        idle();
    endtask

    // driver side of the scoreboard: record what a row should hold
    task automatic expect_row(input int base, input string tag);
        for (int c = 0; c < 64; c++) exp_q.push_back('{base + c, model[base + c], tag});
    endtask

    // monitor side: read the array and compare in order
    task automatic drain();
        while (exp_q.size() > 0) begin
            exp_t e = exp_q.pop_front();
            @(negedge clk); rd_addr = AW'(e.addr);
            #1 check(e.tag, int'(rd_data), e.data);
        end
    endtask

    task automatic wait_cycle(input string tag);
        int n = 0;
        check({tag, " busy after STOP"}, int'(busy), 1);
        while (busy) begin n++; @(negedge clk); end
        check({tag, " busy length"}, n, WCYC);
    endtask

    initial begin
        int n;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 addr_cnt", int'(addr_cnt), 0);
        expect_row(0, "R1 erased");
        expect_row(960, "R1 erased");
        drain();

        // R2 single byte; R5 neighbours unchanged
        send_addr('h085); send_byte('h3C, 0, 1);
        rd_addr = AW'('h085);
        send_stop();
        #1 check("R2 not yet committed", int'(rd_data), 'hFF);
        wait_cycle("R2");
        model['h085] = 'h3C;
        expect_row('h080, "R2/R5 byte write");
        drain();

        // R3 page write from column 60, R4 wrap inside row
        send_addr('h13C);
        for (int i = 0; i < 6; i++) send_byte('hA0 + i, 0, 1);
        check("R4 addr_cnt wrapped", int'(addr_cnt), 'h102);
        send_stop(); wait_cycle("R3");
        for (int i = 0; i < 6; i++) model['h100 + ((60 + i) % 64)] = 'hA0 + i;
        expect_row('h100, "R3/R4 page write");
        drain();

        // R4 66 bytes: two columns overwritten in the latch
        send_addr('h1C0);
        for (int i = 0; i < 66; i++) send_byte(i + 1, 0, 1);
        check("R4 addr_cnt after 66", int'(addr_cnt), 'h1C2);
        send_stop(); wait_cycle("R4");
        for (int i = 0; i < 66; i++) model['h1C0 + (i % 64)] = i + 1;
        expect_row('h1C0, "R4 overwrite");
        drain();

        // R6 STOP outside the acknowledge slot
        send_addr('h200); send_byte('h55, 0, 1);
        @(negedge clk); bit_evt = 1; idle();
        send_stop();
        check("R6 no cycle", int'(busy), 0);
        repeat (WCYC + 2) @(negedge clk);
        expect_row('h200, "R6 array untouched");
        drain();
        // latch discarded: a later address-only STOP in slot starts nothing
        send_addr('h205); send_stop();
        check("R6 latch discarded", int'(busy), 0);

        // R7 refused bytes
        send_addr('h240);
        send_byte('h11, 0, 1); send_byte('h22, 1, 0); send_byte('h33, 0, 1);
        check("R7 counter advances on refused", int'(addr_cnt), 'h243);
        send_stop(); wait_cycle("R7");
        model['h240] = 'h11; model['h242] = 'h33;
        expect_row('h240, "R7 protected byte");
        drain();
        send_addr('h280); send_byte('h77, 1, 0);
        @(negedge clk); ack_evt = 1; idle();
        send_stop();
        check("R7 all refused no cycle", int'(busy), 0);

        // R8 zero-byte write
        send_addr('h2C5); send_stop();
        check("R8 addr_cnt set", int'(addr_cnt), 'h2C5);
        check("R8 no cycle", int'(busy), 0);

        // R9 inputs ignored while busy, R10 accepted right after
        send_addr('h300); send_byte('h9A, 0, 1); send_stop();
        check("R9 busy", int'(busy), 1);
        send_addr('h3FF); send_byte('h99, 0, 1); send_stop();
        check("R9 addr_cnt held", int'(addr_cnt), 'h301);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        model['h300] = 'h9A;
        expect_row('h300, "R9 ignored traffic");
        expect_row('h3C0, "R9 ignored traffic");
        drain();
        check("R9 no second cycle", int'(busy), 0);
        send_addr('h345);
        check("R10 load after cycle", int'(addr_cnt), 'h345);
        send_byte('h5A, 0, 1); send_stop(); wait_cycle("R10");
        model['h345] = 'h5A;
        expect_row('h340, "R10 write after cycle");
        drain();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule